// File: doc/BRIEF.md
# Shared Pipelined Pilot Least-Squares Channel Estimator

This block forms least-squares channel estimates at pilot positions for one receive antenna that hears the pilots of two transmit antennas. Each received pilot sample is multiplied by the complex conjugate of the known pilot for that position. Both transmitters send the same pilot sequence, so one internal reference table and one complex multiplier serve both streams. The two streams are taken turn about: first a transmit-0 pilot, then the transmit-1 pilot of the same index.

Every sample is 16-bit signed fixed point with one sign bit, one integer bit and 14 fraction bits, so 1.0 is 16384. Input and output use valid/ready handshakes. A beat moves on a rising edge only when valid and ready are both high. A start-of-symbol flag on the transmit-0 input restarts the pilot index at 0. Each estimate leaves tagged with its transmit stream and its pilot index, three clocks after the beat was accepted, unless the output is stalled.

Top module: `ls_pair_estimator`

## Requirements
- R1: For received pilot (Rr, Ri) and reference (Lr, Li), the block computes the real sum Rr·Lr + Ri·Li and the imaginary difference Ri·Lr − Rr·Li at full precision. Each result is arithmetically shifted right by 14 (rounding toward minus infinity) and saturated to the range −32768..32767.
- R2: The reference for pilot index k has magnitude 11585 in each part. The real part is negative exactly when bit 1 of k XOR bit 3 of k is 1. The imaginary part is negative exactly when bit 0 of k XOR bit 2 of k is 1.
- R3: After reset the block accepts only stream 0 (`s0_ready` high, `s1_ready` low). After a stream-0 beat it accepts only stream 1, and after a stream-1 beat it accepts only stream 0 again.
- R4: A stream-1 beat uses the same pilot index as the stream-0 beat before it. The index advances by one after each stream-1 beat and wraps from NPILOT−1 (default 99) to 0.
- R5: A stream-0 beat accepted with `s0_sos` high uses index 0, whatever the previous index was. The pair that follows uses index 1.
- R6: An accepted beat appears on the output exactly 3 cycles later, plus one cycle for every cycle in which the output was stalled in between.
- R7: While `m_valid` is high and `m_ready` is low, all output fields hold stable and both input readies are low.
- R8: `m_tx` is 0 for an estimate from stream 0 and 1 for an estimate from stream 1.
- R9: After reset `m_valid` is low.
- R10: A result whose shifted value lies outside the 16-bit range is clamped to 32767 or −32768.
- R11: No estimate is produced for a cycle in which the selected input's valid is low. A beat enters only on valid and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_valid | input | 1 | Transmit-0 pilot beat valid |
| s0_ready | output | 1 | Transmit-0 pilot beat accepted |
| s0_re | input | 16 | Transmit-0 received pilot, real |
| s0_im | input | 16 | Transmit-0 received pilot, imaginary |
| s0_sos | input | 1 | First pilot of a pilot-bearing symbol |
| s1_valid | input | 1 | Transmit-1 pilot beat valid |
| s1_ready | output | 1 | Transmit-1 pilot beat accepted |
| s1_re | input | 16 | Transmit-1 received pilot, real |
| s1_im | input | 16 | Transmit-1 received pilot, imaginary |
| m_valid | output | 1 | Estimate valid |
| m_ready | input | 1 | Downstream accepts estimate |
| m_re | output | 16 | Estimate, real |
| m_im | output | 16 | Estimate, imaginary |
| m_tx | output | 1 | Transmit stream of the estimate |
| m_idx | output | 7 | Pilot index of the estimate |

## Verification
The bench goes after extreme inputs such as −32768 at both parts of the pilot. There the shifted sum exceeds the 16-bit range, and a design without clamping would wrap and flip sign. It runs long stretches without start-of-symbol flags so the index passes 99. A design that wrapped late or skipped the clamp at the top would emit index 100 or lose pairing. It mixes start-of-symbol flags at arbitrary points, which catches an index that restarts one beat late. Random backpressure catches a pipeline that keeps accepting input or changes its output while stalled. Starved inputs catch an arbiter that lets stream 1 go first or twice in a row.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int SW        = 16;
  localparam int FRAC      = 14;
  localparam int PW        = 2 * SW;
  localparam int NPILOT_DEF = 100;
  localparam int PILOT_AMP = 11585;

  typedef struct packed {
    logic signed [SW-1:0] re;
    logic signed [SW-1:0] im;
  } cplx_t;

  // Known pilot value at index k (sign pattern from bits of k).
  function automatic cplx_t ref_pilot(input int k);
    logic [31:0] u;
    cplx_t c;
    u = k;
    c.re = (u[1] ^ u[3]) ? -SW'(PILOT_AMP) : SW'(PILOT_AMP);
    c.im = (u[0] ^ u[2]) ? -SW'(PILOT_AMP) : SW'(PILOT_AMP);
    return c;
  endfunction

  function automatic logic signed [PW:0] add_ext(input logic signed [PW-1:0] a,
                                                  input logic signed [PW-1:0] b);
    return {a[PW-1], a} + {b[PW-1], b};
  endfunction

  function automatic logic signed [PW:0] sub_ext(input logic signed [PW-1:0] a,
                                                  input logic signed [PW-1:0] b);
    return {a[PW-1], a} - {b[PW-1], b};
  endfunction

  // Back to 1.1.14: floor shift, then clamp to the signed SW range.
  function automatic logic signed [SW-1:0] rescale_sat(input logic signed [PW:0] s);
    logic signed [PW:0] t;
    logic signed [PW:0] hi;
    logic signed [PW:0] lo;
    t  = s >>> FRAC;
    hi = (PW+1)'((1 <<< (SW-1)) - 1);
    lo = -(PW+1)'(1 <<< (SW-1));
    if (t > hi) return {1'b0, {(SW-1){1'b1}}};
    if (t < lo) return {1'b1, {(SW-1){1'b0}}};
    return t[SW-1:0];
  endfunction
endpackage

// File: rtl/est_pilot_rom.sv
module est_pilot_rom #(
  parameter int NPILOT = lsq_pkg::NPILOT_DEF,
  localparam int IDXW  = $clog2(NPILOT)
) (
  input  logic [IDXW-1:0] addr,
  output lsq_pkg::cplx_t  q
);
  lsq_pkg::cplx_t tbl [NPILOT];

  for (genvar k = 0; k < NPILOT; k++) begin : g_ent
    assign tbl[k] = lsq_pkg::ref_pilot(k);
  end

  assign q = tbl[addr];
endmodule

// File: rtl/est_pair_arb.sv
module est_pair_arb #(
  parameter int NPILOT = lsq_pkg::NPILOT_DEF,
  localparam int IDXW  = $clog2(NPILOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            s0_valid,
  input  logic            s0_sos,
  input  logic            s1_valid,
  output logic            s0_ready,
  output logic            s1_ready,
  output logic            take0,
  output logic            take1,
  output logic [IDXW-1:0] rom_addr
);
  typedef enum logic {WAIT_TX0, WAIT_TX1} arb_state_e;

  arb_state_e      state_q;
  logic [IDXW-1:0] addr_q;
  logic [IDXW-1:0] hold_q;
  logic            last_idx;

  assign s0_ready = advance && (state_q == WAIT_TX0);
  assign s1_ready = advance && (state_q == WAIT_TX1);
  assign take0    = s0_ready && s0_valid;
  assign take1    = s1_ready && s1_valid;
  assign last_idx = (hold_q == IDXW'(NPILOT - 1));

  always_comb begin
    if (state_q == WAIT_TX0) rom_addr = s0_sos ? '0 : addr_q;
    else                     rom_addr = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WAIT_TX0;
      addr_q  <= '0;
      hold_q  <= '0;
    end else if (take0) begin
      state_q <= WAIT_TX1;
      hold_q  <= rom_addr;
    end else if (take1) begin
      state_q <= WAIT_TX0;
      addr_q  <= last_idx ? '0 : hold_q + 1'b1;
    end
  end
endmodule

// File: rtl/est_cmul_pipe.sv
module est_cmul_pipe #(
  parameter int NPILOT = lsq_pkg::NPILOT_DEF,
  localparam int IDXW  = $clog2(NPILOT),
  localparam int PW    = lsq_pkg::PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            in_valid,
  input  lsq_pkg::cplx_t  in_rx,
  input  lsq_pkg::cplx_t  in_ref,
  input  logic            in_tx,
  input  logic [IDXW-1:0] in_idx,
  output logic            out_valid,
  output lsq_pkg::cplx_t  out_est,
  output logic            out_tx,
  output logic [IDXW-1:0] out_idx
);
  localparam int NST = 3;

  logic [NST-1:0]         v_q;
  logic [NST-1:0]         tx_q;
  logic [IDXW-1:0]        idx_q [NST];

  logic signed [PW-1:0]   p_rr, p_ii, p_ir, p_ri;
  logic signed [PW:0]     s_re, s_im;
  lsq_pkg::cplx_t         est_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else if (advance) v_q <= {v_q[NST-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      tx_q     <= {tx_q[NST-2:0], in_tx};
      idx_q[0] <= in_idx;
      for (int i = 1; i < NST; i++) idx_q[i] <= idx_q[i-1];
      // stage 1: products
      p_rr <= in_rx.re * in_ref.re;
      p_ii <= in_rx.im * in_ref.im;
      p_ir <= in_rx.im * in_ref.re;
      p_ri <= in_rx.re * in_ref.im;
      // stage 2: conjugate combine
      s_re <= lsq_pkg::add_ext(p_rr, p_ii);
      s_im <= lsq_pkg::sub_ext(p_ir, p_ri);
      // stage 3: rescale with clamp
      est_q.re <= lsq_pkg::rescale_sat(s_re);
      est_q.im <= lsq_pkg::rescale_sat(s_im);
    end
  end

  assign out_valid = v_q[NST-1];
  assign out_est   = est_q;
  assign out_tx    = tx_q[NST-1];
  assign out_idx   = idx_q[NST-1];
endmodule

// File: rtl/ls_pair_estimator.sv
module ls_pair_estimator #(
  parameter int NPILOT = lsq_pkg::NPILOT_DEF,
  localparam int SW    = lsq_pkg::SW,
  localparam int IDXW  = $clog2(NPILOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s0_valid,
  output logic                 s0_ready,
  input  logic signed [SW-1:0] s0_re,
  input  logic signed [SW-1:0] s0_im,
  input  logic                 s0_sos,
  input  logic                 s1_valid,
  output logic                 s1_ready,
  input  logic signed [SW-1:0] s1_re,
  input  logic signed [SW-1:0] s1_im,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [SW-1:0] m_re,
  output logic signed [SW-1:0] m_im,
  output logic                 m_tx,
  output logic [IDXW-1:0]      m_idx
);
  // named internal events (observed by the bound checker)
  logic            advance;
  logic            take0;
  logic            take1;
  logic [IDXW-1:0] rom_addr;
  lsq_pkg::cplx_t  ref_val;
  lsq_pkg::cplx_t  rx_val;
  lsq_pkg::cplx_t  est;

  assign advance = !m_valid || m_ready;

  est_pair_arb #(.NPILOT(NPILOT)) u_arb (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .s0_valid(s0_valid), .s0_sos(s0_sos), .s1_valid(s1_valid),
    .s0_ready(s0_ready), .s1_ready(s1_ready),
    .take0(take0), .take1(take1), .rom_addr(rom_addr)
  );

  est_pilot_rom #(.NPILOT(NPILOT)) u_rom (.addr(rom_addr), .q(ref_val));

  always_comb begin
    rx_val.re = take1 ? s1_re : s0_re;
    rx_val.im = take1 ? s1_im : s0_im;
  end

  est_cmul_pipe #(.NPILOT(NPILOT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .in_valid(take0 || take1), .in_rx(rx_val), .in_ref(ref_val),
    .in_tx(take1), .in_idx(rom_addr),
    .out_valid(m_valid), .out_est(est), .out_tx(m_tx), .out_idx(m_idx)
  );

  assign m_re = est.re;
  assign m_im = est.im;
endmodule

// File: rtl/ls_pair_estimator_chk.sv
module ls_pair_estimator_chk #(
  parameter int NPILOT = lsq_pkg::NPILOT_DEF,
  localparam int SW    = lsq_pkg::SW,
  localparam int IDXW  = $clog2(NPILOT)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 take0,
  input logic                 take1,
  input logic                 s0_ready,
  input logic                 s1_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic signed [SW-1:0] m_re,
  input logic signed [SW-1:0] m_im,
  input logic                 m_tx,
  input logic [IDXW-1:0]      m_idx
);
  logic       last_was1;
  logic [2:0] inflight;
  logic       emit;

  assign emit = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_was1 <= 1'b1;
      inflight  <= '0;
    end else begin
      if (take0) last_was1 <= 1'b0;
      else if (take1) last_was1 <= 1'b1;
      inflight <= inflight + 3'(take0 || take1) - 3'(emit);
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_re) && $stable(m_im)
                            && $stable(m_tx) && $stable(m_idx));
  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s0_ready && !s1_ready);
  // R3
  alt_tx0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take0 |-> last_was1);
  // R3
  alt_tx1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take1 |-> !last_was1);
  // R6
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd3);
  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> int'(m_idx) < NPILOT);
endmodule

bind ls_pair_estimator ls_pair_estimator_chk #(.NPILOT(NPILOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .take0(take0), .take1(take1),
  .s0_ready(s0_ready), .s1_ready(s1_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_re(m_re), .m_im(m_im),
  .m_tx(m_tx), .m_idx(m_idx)
);

// File: tb/tb_ls_pair_estimator.sv
`timescale 1ns/1ps
module tb_ls_pair_estimator;
  logic clk = 0, rst_n = 0;
  logic s0_valid = 0, s0_sos = 0, s1_valid = 0, m_ready = 0;
  logic signed [15:0] s0_re = 0, s0_im = 0, s1_re = 0, s1_im = 0;
  logic s0_ready, s1_ready, m_valid, m_tx;
  logic signed [15:0] m_re, m_im;
  logic [6:0] m_idx;

  always #2.5 clk = ~clk;

  ls_pair_estimator dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, stall_cnt = 0;
  int nxt = 0, addr = 0, hold = 0;
  int q_re[$], q_im[$], q_tx[$], q_idx[$], q_cyc[$], q_st[$];
  bit prev_stall = 0, done = 0;
  logic signed [15:0] p_re, p_im;
  logic p_tx;
  logic [6:0] p_idx;
  bit acc0 = 0, acc1 = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int ref_re(input int k);
    return (((k >> 1) ^ (k >> 3)) & 1) ? -11585 : 11585;
  endfunction
  function automatic int ref_im(input int k);
    return ((k ^ (k >> 2)) & 1) ? -11585 : 11585;
  endfunction
  function automatic int clamp14(input longint v);
    longint t = v >>> 14;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  function automatic logic signed [15:0] pick(input int mode);
    int sel;
    if (mode == 0) return 16'($signed($urandom_range(8192)) - 4096);
    if (mode == 1) return 16'($urandom);
    sel = $urandom_range(3);
    case (sel)
      0: return -16'sd32768;
      1: return 16'sd32767;
      2: return -16'sd32767;
      default: return -16'sd32768;
    endcase
  endfunction

  task automatic push_exp(input int rr, input int ri, input int k, input int tx);
    longint lr = ref_re(k), li = ref_im(k);
    q_re.push_back(clamp14(longint'(rr) * lr + longint'(ri) * li));
    q_im.push_back(clamp14(longint'(ri) * lr - longint'(rr) * li));
    q_tx.push_back(tx);
    q_idx.push_back(k);
    q_cyc.push_back(cyc);
    q_st.push_back(stall_cnt);
  endtask

  task automatic step(input int pv0, input int pv1, input int prdy, input int mode,
                      input int psos);
    bit stall, e0, e1;
    int k, lat;
    @(negedge clk);
    if (acc0) s0_valid = 0;
    if (acc1) s1_valid = 0;
    if (!s0_valid && $urandom_range(99) < pv0) begin
      s0_valid = 1; s0_re = pick(mode); s0_im = pick(mode);
      s0_sos = ($urandom_range(99) < psos);
    end
    if (!s1_valid && $urandom_range(99) < pv1) begin
      s1_valid = 1; s1_re = pick(mode); s1_im = pick(mode);
    end
    m_ready = ($urandom_range(99) < prdy);
    #2;
    cyc++;
    stall = m_valid && !m_ready;
    e0 = !stall && nxt == 0;
    e1 = !stall && nxt == 1;
    // R3 alternation, R7 readies low while stalled
    chk(s0_ready == e0, "R3/R7 s0_ready", s0_ready, e0);
    chk(s1_ready == e1, "R3/R7 s1_ready", s1_ready, e1);
    if (prev_stall) begin
      chk(m_valid == 1, "R7 valid held", m_valid, 1);
      chk(m_re == p_re && m_im == p_im, "R7 data held", m_re, p_re);
      chk(m_tx == p_tx && m_idx == p_idx, "R7 tag held", m_idx, p_idx);
    end
    if (m_valid && m_ready) begin
      if (q_re.size() == 0) chk(0, "R11 spurious output", 1, 0);
      else begin
        chk(m_re == q_re[0], "R1/R2/R10 real", m_re, q_re[0]);
        chk(m_im == q_im[0], "R1/R2/R10 imag", m_im, q_im[0]);
        chk(m_tx == q_tx[0], "R8 tag", m_tx, q_tx[0]);
        chk(m_idx == q_idx[0], "R4/R5 index", m_idx, q_idx[0]);
        lat = 3 + stall_cnt - q_st[0];
        chk(cyc - q_cyc[0] == lat, "R6 latency", cyc - q_cyc[0], lat);
        void'(q_re.pop_front()); void'(q_im.pop_front()); void'(q_tx.pop_front());
        void'(q_idx.pop_front()); void'(q_cyc.pop_front()); void'(q_st.pop_front());
      end
    end
    acc0 = s0_valid && s0_ready;
    acc1 = s1_valid && s1_ready;
    if (acc0) begin
      k = s0_sos ? 0 : addr;
      hold = k; nxt = 1;
      push_exp(s0_re, s0_im, k, 0);
    end
    if (acc1) begin
      push_exp(s1_re, s1_im, hold, 1);
      addr = (hold + 1) % 100; nxt = 0;
    end
    if (stall) stall_cnt++;
    prev_stall = stall;
    p_re = m_re; p_im = m_im; p_tx = m_tx; p_idx = m_idx;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R9 reset state
    chk(m_valid == 0, "R9 m_valid after reset", m_valid, 0);
    chk(s0_ready == 1, "R3 s0_ready after reset", s0_ready, 1);
    chk(s1_ready == 0, "R3 s1_ready after reset", s1_ready, 0);
    // only stream 1 offered first: nothing may enter (R3, R11)
    repeat (10) step(0, 100, 100, 0, 0);
    chk(q_re.size() == 0, "R11 no entry when starved", q_re.size(), 0);
    repeat (150) step(100, 100, 100, 0, 0);
    repeat (900) step(80, 80, 100, 1, 0);   // long run, index wraps (R4)
    repeat (1500) step(70, 70, 50, 1, 10);  // sos mixed in (R5), backpressure (R7)
    repeat (500) step(90, 90, 70, 2, 5);    // extremes to hit clamps (R10)
    repeat (20) step(0, 0, 100, 0, 0);      // drain, no new input (R11)
    chk(q_re.size() == 0, "R11 all estimates delivered", q_re.size(), 0);
    chk(m_valid == 0, "R11 idle output", m_valid, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule